// File: doc/BRIEF.md
# Hash accelerator register front-end

This block is the register-mapped shell around a block-hash compression core that handles SHA-1 and MD5. A host reads and writes 32-bit words over a small request/response bus. Through it the host holds the digest context and a count of bytes already hashed. It opens a segment by writing a byte length with three mode bits: algorithm, start from initial constants, and close the hash. It then feeds the message through a window of sixteen data words.

Each time a block is complete, the front-end offers the block, the current digest, the block's byte count and the running total to the external core. This happens when the last window word is written, or when a word covers the last byte of the segment. The core returns a new digest, which replaces the context. Because the digest and byte count can be read and written back, a long message can be split across many segments, and contexts can be swapped in and out between segments. Completion is signalled by an output-ready bit, an active-low level interrupt and, while input is wanted, a DMA request.

Bus handshake: `req_ready` is always high, so every request completes in the cycle it is presented. A read answers one cycle later with `rsp_valid` and has no back-pressure. Toward the core, `core_start_valid` stays high with all offered fields stable until the core raises `core_start_ready`. The core later pulses `core_done_valid` for one cycle with the new digest, and the front-end always accepts it.

Top module: `hfe_top`

## Requirements
- R1: After reset the control word reads 0, status bit 0 reads 1, `irq_n` is 1, `dma_req` is 0, no block is offered, and offset 0x5C reads the major revision in bits 7:4 and the minor revision in bits 3:0.
- R2: Word offsets are: digest words 0x00–0x10, byte count 0x14, control 0x18, data window 0x1C–0x58, revision 0x5C, config 0x60, status 0x64. Any other offset, or an address with nonzero bits 1:0, reads 0 and ignores writes. Every read returns `rsp_valid` high one cycle after the request.
- R3: Control bits are: 0 output-ready, 1 input-ready (read-only), 2 algorithm (1 = SHA-1), 3 load constants, 4 close, 31:5 segment length in bytes. A write with a nonzero length opens a segment, sets input-ready and clears the window. A write with a zero length clears input-ready and idles the block.
- R4: Data-window writes made while input-ready is 0 have no effect: no block is offered and input-ready stays 0.
- R5: A block is offered when window word 15 is written, or when a written word index k satisfies 4(k+1) ≥ remaining bytes; no earlier write offers it. The offered length is min(64, remaining), unwritten words are 0, and input-ready drops while the block is out.
- R6: An offered block's `core_start_valid`, contents and length stay stable until `core_start_ready`.
- R7: `core_init` equals the load-constants bit for the first block of a segment only. `core_last` is high exactly for the segment's final block when close is set. `core_total` is the byte count plus the block length.
- R8: On `core_done_valid` the digest registers take the core's output and the byte count grows by the block length. Input-ready then returns if bytes remain; otherwise output-ready is set.
- R9: Writing control with bit 0 set clears output-ready. `irq_n` is low exactly while output-ready and config bit 2 (interrupt enable) are both 1.
- R10: `dma_req` is high exactly while config bit 3 (DMA enable) and input-ready are both 1.
- R11: With algorithm bit 1 (SHA-1), digest register reads and writes are byte-swapped relative to the core's word order; with 0 (MD5) they pass unchanged. A write followed by a read returns the written value.
- R12: Writing config with bit 1 set clears digest, count, control and config. Status bit 0 reads 0 in the next cycle and 1 after that. Config bit 1 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Bus request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| core_start_valid | output | 1 | Block offered to the core |
| core_start_ready | input | 1 | Core takes the block |
| core_algo | output | 1 | 1 = SHA-1, 0 = MD5 |
| core_init | output | 1 | Start from initial constants |
| core_last | output | 1 | Final block: pad and close |
| core_len | output | 7 | Bytes valid in this block |
| core_total | output | 32 | Total bytes hashed including this block |
| core_digest_in | output | 160 | Current digest, word 0 lowest |
| core_block | output | 512 | Block data, word 0 lowest |
| core_done_valid | input | 1 | Core result valid (one cycle) |
| core_digest_out | input | 160 | Resulting digest |
| irq_n | output | 1 | Active-low completion interrupt |
| dma_req | output | 1 | DMA request for the data window |

## Verification
The hardest state to reach is a segment that spans several blocks and continues a restored context. That requires digest and count values written through the byte-swapped view, a length beyond one block, and a core that accepts and finishes with varying delays. The bench's core model stalls the start handshake and the result by random amounts. Segments of random length, algorithm and flags run after directed cases: a restored two-block segment, a 10-byte tail that must not start early, and a segment abandoned by a zero-length write. Every offered block is compared against the bench's own model of digest chaining and byte totals.

// File: rtl/hfe_pkg.sv
package hfe_pkg;
  localparam int WORD_W = 32;

  // control word bit positions
  localparam int CTRL_ORDY    = 0;
  localparam int CTRL_IRDY    = 1;
  localparam int CTRL_ALGO    = 2;
  localparam int CTRL_INIT    = 3;
  localparam int CTRL_CLOSE   = 4;
  localparam int CTRL_LEN_LSB = 5;

  // config word bit positions
  localparam int CFG_IDLE  = 0;
  localparam int CFG_SRST  = 1;
  localparam int CFG_IRQEN = 2;
  localparam int CFG_DMAEN = 3;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_LAUNCH, S_WAIT} seq_state_e;

  function automatic logic [WORD_W-1:0] bswap32(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/hfe_blkbuf.sv
module hfe_blkbuf import hfe_pkg::*; #(
  parameter int BLK_WORDS = 16,
  localparam int IDX_W = $clog2(BLK_WORDS),
  localparam int BLK_W = BLK_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic [BLK_W-1:0]  blk
);
  for (genvar g = 0; g < BLK_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] w_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 w_q <= '0;
      else if (clr)                               w_q <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))      w_q <= wr_data;
    end
    assign blk[g*WORD_W +: WORD_W] = w_q;
  end
endmodule

// File: rtl/hfe_seq.sv
module hfe_seq import hfe_pkg::*; #(
  parameter int BLK_WORDS = 16,
  parameter int LEN_W = 27,
  localparam int IDX_W = $clog2(BLK_WORDS),
  localparam int BLK_BYTES = BLK_WORDS * 4,
  localparam int BLEN_W = $clog2(BLK_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              seg_go,
  input  logic              seg_stop,
  input  logic [LEN_W-1:0]  seg_len,
  input  logic              seg_init,
  input  logic              seg_close,
  input  logic              din_wr,
  input  logic [IDX_W-1:0]  din_idx,
  input  logic              start_ready,
  input  logic              done_valid,
  output logic              in_rdy,
  output logic              start_valid,
  output logic [BLEN_W-1:0] blk_len,
  output logic              core_init,
  output logic              core_last,
  output logic              blk_done,
  output logic              seg_done
);
  localparam int CMP_W = LEN_W + 2;

  seq_state_e       st_q;
  logic [LEN_W-1:0] rem_q;
  logic [BLEN_W-1:0] blen_q;
  logic             init_q, close_q, last_q;

  logic [CMP_W-1:0] seen, rem_ext;
  logic             full_blk, fire, ctl_hit;
  logic [BLEN_W-1:0] cur_blen;

  assign rem_ext  = CMP_W'(rem_q);
  assign seen     = CMP_W'({din_idx, 2'b00}) + CMP_W'(4);
  assign full_blk = rem_ext >= CMP_W'(BLK_BYTES);
  assign cur_blen = full_blk ? BLEN_W'(BLK_BYTES) : rem_q[BLEN_W-1:0];
  assign fire     = (st_q == S_FILL) && din_wr &&
                    (din_idx == IDX_W'(BLK_WORDS - 1) || seen >= rem_ext);
  assign ctl_hit  = flush || seg_stop || seg_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; rem_q <= '0; blen_q <= '0;
      init_q <= 1'b0; close_q <= 1'b0; last_q <= 1'b0;
    end else if (flush || seg_stop) begin
      st_q <= S_IDLE;
    end else if (seg_go) begin
      st_q    <= S_FILL;
      rem_q   <= seg_len;
      init_q  <= seg_init;
      close_q <= seg_close;
    end else begin
      unique case (st_q)
        S_FILL: if (fire) begin
          blen_q <= cur_blen;
          last_q <= close_q && (rem_ext <= CMP_W'(BLK_BYTES));
          st_q   <= S_LAUNCH;
        end
        S_LAUNCH: if (start_ready) st_q <= S_WAIT;
        S_WAIT: if (done_valid) begin
          init_q <= 1'b0;
          rem_q  <= rem_q - LEN_W'(blen_q);
          st_q   <= (rem_q == LEN_W'(blen_q)) ? S_IDLE : S_FILL;
        end
        default: ;
      endcase
    end
  end

  assign in_rdy      = (st_q == S_FILL);
  assign start_valid = (st_q == S_LAUNCH);
  assign blk_len     = blen_q;
  assign core_init   = init_q;
  assign core_last   = last_q;
  assign blk_done    = (st_q == S_WAIT) && done_valid && !ctl_hit;
  assign seg_done    = blk_done && (rem_q == LEN_W'(blen_q));
endmodule

// File: rtl/hfe_top.sv
module hfe_top import hfe_pkg::*; #(
  parameter int ADDR_W    = 7,
  parameter int DIG_WORDS = 5,
  parameter int BLK_WORDS = 16,
  parameter logic [3:0] REV_MAJOR = 4'd2,
  parameter logic [3:0] REV_MINOR = 4'd1,
  localparam int DIG_W     = DIG_WORDS * WORD_W,
  localparam int BLK_W     = BLK_WORDS * WORD_W,
  localparam int BLEN_W    = $clog2(BLK_WORDS * 4) + 1,
  localparam int LEN_W     = WORD_W - CTRL_LEN_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              core_start_valid,
  input  logic              core_start_ready,
  output logic              core_algo,
  output logic              core_init,
  output logic              core_last,
  output logic [BLEN_W-1:0] core_len,
  output logic [WORD_W-1:0] core_total,
  output logic [DIG_W-1:0]  core_digest_in,
  output logic [BLK_W-1:0]  core_block,
  input  logic              core_done_valid,
  input  logic [DIG_W-1:0]  core_digest_out,
  output logic              irq_n,
  output logic              dma_req
);
  localparam int WIDX_W   = ADDR_W - 2;
  localparam int IDX_W    = $clog2(BLK_WORDS);
  localparam int IDX_CNT  = DIG_WORDS;
  localparam int IDX_CTRL = DIG_WORDS + 1;
  localparam int IDX_DIN  = DIG_WORDS + 2;
  localparam int IDX_REV  = IDX_DIN + BLK_WORDS;
  localparam int IDX_CFG  = IDX_REV + 1;
  localparam int IDX_STAT = IDX_CFG + 1;

  // ---------------- decode ----------------
  logic [WIDX_W-1:0] widx;
  logic aligned, wr, rd, ctrl_wr, cfg_wr, cnt_wr, din_hit, din_wr, srst_wr;
  logic seg_go, seg_stop;
  logic [IDX_W-1:0] din_idx;

  assign req_ready = 1'b1;
  assign widx      = req_addr[ADDR_W-1:2];
  assign aligned   = (req_addr[1:0] == 2'b00);
  assign wr        = req_valid && req_write && aligned;
  assign rd        = req_valid && !req_write;
  assign ctrl_wr   = wr && (int'(widx) == IDX_CTRL);
  assign cfg_wr    = wr && (int'(widx) == IDX_CFG);
  assign cnt_wr    = wr && (int'(widx) == IDX_CNT);
  assign din_hit   = (int'(widx) >= IDX_DIN) && (int'(widx) < IDX_REV);
  assign din_idx   = IDX_W'(int'(widx) - IDX_DIN);
  assign srst_wr   = cfg_wr && req_wdata[CFG_SRST];
  assign seg_go    = ctrl_wr && (req_wdata[WORD_W-1:CTRL_LEN_LSB] != '0);
  assign seg_stop  = ctrl_wr && (req_wdata[WORD_W-1:CTRL_LEN_LSB] == '0);

  // ---------------- state ----------------
  logic algo_q, init_q, close_q, ordy_q, idle_q, irqen_q, dmaen_q, rst_done_q;
  logic [LEN_W-1:0]  len_q;
  logic [WORD_W-1:0] cnt_q;
  logic in_rdy, blk_done, seg_done;
  logic [BLEN_W-1:0] blk_len;

  assign din_wr = wr && din_hit && in_rdy;

  hfe_seq #(.BLK_WORDS(BLK_WORDS), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .flush(srst_wr),
    .seg_go(seg_go), .seg_stop(seg_stop),
    .seg_len(req_wdata[WORD_W-1:CTRL_LEN_LSB]),
    .seg_init(req_wdata[CTRL_INIT]), .seg_close(req_wdata[CTRL_CLOSE]),
    .din_wr(din_wr), .din_idx(din_idx),
    .start_ready(core_start_ready), .done_valid(core_done_valid),
    .in_rdy(in_rdy), .start_valid(core_start_valid), .blk_len(blk_len),
    .core_init(core_init), .core_last(core_last),
    .blk_done(blk_done), .seg_done(seg_done)
  );

  hfe_blkbuf #(.BLK_WORDS(BLK_WORDS)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(seg_go || srst_wr || blk_done),
    .wr_en(din_wr), .wr_idx(din_idx), .wr_data(req_wdata), .blk(core_block)
  );

  // digest context, held in core word order; host view swapped for SHA-1
  logic [DIG_W-1:0] dig_host;
  for (genvar g = 0; g < DIG_WORDS; g++) begin : g_dig
    logic [WORD_W-1:0] d_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        d_q <= '0;
      else if (srst_wr)  d_q <= '0;
      else if (blk_done) d_q <= core_digest_out[g*WORD_W +: WORD_W];
      else if (wr && widx == WIDX_W'(g))
        d_q <= algo_q ? bswap32(req_wdata) : req_wdata;
    end
    assign core_digest_in[g*WORD_W +: WORD_W] = d_q;
    assign dig_host[g*WORD_W +: WORD_W]       = algo_q ? bswap32(d_q) : d_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      algo_q <= 1'b0; init_q <= 1'b0; close_q <= 1'b0; len_q <= '0;
      ordy_q <= 1'b0; idle_q <= 1'b0; irqen_q <= 1'b0; dmaen_q <= 1'b0;
      cnt_q <= '0; rst_done_q <= 1'b1;
    end else begin
      rst_done_q <= !srst_wr;
      if (srst_wr) begin
        algo_q <= 1'b0; init_q <= 1'b0; close_q <= 1'b0; len_q <= '0;
        ordy_q <= 1'b0; idle_q <= 1'b0; irqen_q <= 1'b0; dmaen_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        if (ctrl_wr) begin
          algo_q  <= req_wdata[CTRL_ALGO];
          init_q  <= req_wdata[CTRL_INIT];
          close_q <= req_wdata[CTRL_CLOSE];
          len_q   <= req_wdata[WORD_W-1:CTRL_LEN_LSB];
        end
        if (seg_done)                             ordy_q <= 1'b1;
        else if (ctrl_wr && req_wdata[CTRL_ORDY]) ordy_q <= 1'b0;
        if (cfg_wr) begin
          idle_q  <= req_wdata[CFG_IDLE];
          irqen_q <= req_wdata[CFG_IRQEN];
          dmaen_q <= req_wdata[CFG_DMAEN];
        end
        if (blk_done)    cnt_q <= cnt_q + WORD_W'(blk_len);
        else if (cnt_wr) cnt_q <= req_wdata;
      end
    end
  end

  // ---------------- read path ----------------
  logic [WORD_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (!aligned)                       rd_word = '0;
    else if (int'(widx) < DIG_WORDS)    rd_word = dig_host[int'(widx)*WORD_W +: WORD_W];
    else if (int'(widx) == IDX_CNT)     rd_word = cnt_q;
    else if (int'(widx) == IDX_CTRL)    rd_word = {len_q, close_q, init_q, algo_q, in_rdy, ordy_q};
    else if (int'(widx) == IDX_REV)     rd_word = WORD_W'({REV_MAJOR, REV_MINOR});
    else if (int'(widx) == IDX_CFG)     rd_word = WORD_W'({dmaen_q, irqen_q, 1'b0, idle_q});
    else if (int'(widx) == IDX_STAT)    rd_word = WORD_W'(rst_done_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_word;
    end
  end

  assign core_algo  = algo_q;
  assign core_len   = blk_len;
  assign core_total = cnt_q + WORD_W'(blk_len);
  assign irq_n      = !(ordy_q && irqen_q);
  assign dma_req    = dmaen_q && in_rdy;
endmodule

// File: rtl/hfe_chk.sv
module hfe_chk #(
  parameter int BLK_W  = 512,
  parameter int BLEN_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              core_start_valid,
  input logic              core_start_ready,
  input logic [BLK_W-1:0]  core_block,
  input logic [BLEN_W-1:0] core_len,
  input logic              core_done_valid,
  input logic              ctrl_wr,
  input logic              srst_wr,
  input logic              in_rdy,
  input logic              dma_req,
  input logic              ordy_q,
  input logic              rst_done_q,
  input logic [31:0]       cnt_q
);
  p_rsp_follows_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write |=> rsp_valid);

  p_launch_drops_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_start_valid |-> !in_rdy);

  p_start_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    core_start_valid && !core_start_ready && !ctrl_wr && !srst_wr |=>
      core_start_valid && $stable(core_block) && $stable(core_len));

  p_ordy_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ordy_q) |-> $past(core_done_valid));

  p_dma_not_in_flight_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> !core_start_valid);

  p_srst_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    srst_wr |=> (cnt_q == 32'd0) && !rst_done_q && !ordy_q);

  p_srst_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_done_q) |=> rst_done_q);
endmodule

bind hfe_top hfe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .core_start_valid(core_start_valid),
  .core_start_ready(core_start_ready), .core_block(core_block),
  .core_len(core_len), .core_done_valid(core_done_valid),
  .ctrl_wr(ctrl_wr), .srst_wr(srst_wr), .in_rdy(in_rdy), .dma_req(dma_req),
  .ordy_q(ordy_q), .rst_done_q(rst_done_q), .cnt_q(cnt_q)
);

// File: tb/tb_hfe_top.sv
module tb_hfe_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] A_CNT = 7'h14, A_CTRL = 7'h18, A_DIN = 7'h1C,
                         A_REV = 7'h5C, A_CFG = 7'h60, A_STAT = 7'h64;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [6:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic core_start_valid, core_start_ready, core_algo, core_init, core_last;
  logic [6:0] core_len;
  logic [31:0] core_total;
  logic [159:0] core_digest_in, core_digest_out;
  logic [511:0] core_block;
  logic core_done_valid, irq_n, dma_req;

  hfe_top dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, ncap = 0;
  bit finished = 0, last_rv;
  logic [511:0] cap_blk;
  logic [159:0] cap_dig, exp_dig;
  logic [31:0] cap_total, exp_cnt;
  int cap_len;
  bit cap_last, cap_init, cap_algo;

  function automatic logic [31:0] sw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [159:0] mix(input logic [159:0] d, input logic [511:0] b);
    logic [159:0] r;
    logic [31:0] s = 32'h9e3779b9;
    for (int i = 0; i < 16; i++) s = {s[26:0], s[31:27]} ^ b[i*32 +: 32];
    for (int i = 0; i < 5; i++) r[i*32 +: 32] = {d[i*32 +: 31], d[i*32+31]} ^ s ^ 32'(i);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all bus tasks are entered at a falling edge and return at one
  task automatic bus_wr(input logic [6:0] a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_rd(input logic [6:0] a, output logic [31:0] d);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata; last_rv = rsp_valid;
  endtask

  // behavioural compression core with random stalls
  initial begin
    core_start_ready = 0; core_done_valid = 0; core_digest_out = '0;
    forever begin
      @(negedge clk);
      if (rst_n && core_start_valid) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        cap_blk = core_block; cap_dig = core_digest_in; cap_len = int'(core_len);
        cap_last = core_last; cap_init = core_init; cap_algo = core_algo;
        cap_total = core_total;
        core_start_ready = 1;
        @(negedge clk);
        core_start_ready = 0;
        ncap++;
        repeat ($urandom_range(1, 3)) @(negedge clk);
        core_digest_out = mix(cap_dig, cap_blk);
        core_done_valid = 1;
        @(negedge clk);
        core_done_valid = 0;
      end
    end
  end

  task automatic check_context(input bit algo, input string tag);
    logic [31:0] rd;
    bit ok = 1;
    for (int i = 0; i < 5; i++) begin
      bus_rd(7'(i*4), rd);
      if (rd != (algo ? sw(exp_dig[i*32 +: 32]) : exp_dig[i*32 +: 32])) ok = 0;
    end
    chk(ok, {tag, " R8 R11 digest readback"}, 64'(rd), 64'(exp_dig[159:128]));
    bus_rd(A_CNT, rd);
    chk(rd == exp_cnt, {tag, " R8 byte count"}, 64'(rd), 64'(exp_cnt));
  endtask

  task automatic send_segment(input bit algo, input bit init, input bit close, input int len);
    int rem = len;
    bit first = 1;
    logic [31:0] rd;
    bus_wr(A_CTRL, (32'(len) << 5) | {27'b0, close, init, algo, 2'b01});
    while (rem > 0) begin
      int nb = (rem > 64) ? 64 : rem;
      int nw = (nb + 3) / 4;
      int n0 = ncap;
      logic [511:0] blk = '0;
      for (int i = 0; i < nw; i++) blk[i*32 +: 32] = $urandom;
      for (int i = 0; i < nw - 1; i++) bus_wr(7'(A_DIN + 4*i), blk[i*32 +: 32]);
      bus_rd(A_CTRL, rd);
      chk(rd[1] && ncap == n0, "R5 no launch before covering word", 64'(rd), 64'(2));
      bus_wr(7'(A_DIN + 4*(nw-1)), blk[(nw-1)*32 +: 32]);
      for (int k = 0; k < 60; k++) begin
        bus_rd(A_CTRL, rd);
        if (rd[1] || rd[0]) break;
      end
      chk(cap_len == nb && cap_blk == blk, "R5 block length and contents", 64'(cap_len), 64'(nb));
      chk(cap_init == (init && first) && cap_last == (close && rem <= 64) && cap_algo == algo,
          "R7 init/last/algo flags", 64'({cap_init, cap_last, cap_algo}),
          64'({init && first, close && rem <= 64, algo}));
      chk(cap_dig == exp_dig, "R7 R11 digest handed to core", 64'(cap_dig[31:0]), 64'(exp_dig[31:0]));
      chk(cap_total == exp_cnt + 32'(nb), "R7 running total", 64'(cap_total), 64'(exp_cnt + 32'(nb)));
      exp_dig = mix(exp_dig, blk);
      exp_cnt = exp_cnt + 32'(nb);
      rem -= nb;
      first = 0;
      if (rem > 0) chk(rd[1] && !rd[0], "R8 input ready for next block", 64'(rd[1:0]), 64'(2));
      else         chk(rd[0] && !rd[1], "R8 output ready at segment end", 64'(rd[1:0]), 64'(1));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int n0;
    void'($urandom(32'd1234));
    exp_dig = '0; exp_cnt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    chk(irq_n && !dma_req && !core_start_valid && req_ready, "R1 reset pins",
        64'({irq_n, dma_req, core_start_valid}), 64'(4));
    bus_rd(A_CTRL, rd); chk(rd == 0, "R1 control after reset", 64'(rd), 0);
    bus_rd(A_STAT, rd); chk(rd == 1, "R1 status after reset", 64'(rd), 1);
    bus_rd(A_REV, rd);  chk(rd == 32'h21, "R1 revision", 64'(rd), 64'h21);

    // R2 unmapped and misaligned
    bus_rd(7'h68, rd); chk(rd == 0 && last_rv, "R2 unmapped read", 64'(rd), 0);
    bus_wr(7'h15, 32'hdeadbeef); bus_rd(A_CNT, rd);
    chk(rd == 0, "R2 misaligned write ignored", 64'(rd), 0);

    // R11 swapped view in SHA-1 mode; restore a context
    bus_wr(A_CTRL, 32'h4);
    for (int i = 0; i < 5; i++) begin
      logic [31:0] w = $urandom;
      bus_wr(7'(i*4), w);
      exp_dig[i*32 +: 32] = sw(w);
    end
    bus_rd(7'h0, rd); chk(rd == sw(exp_dig[31:0]), "R11 write/read roundtrip", 64'(rd), 64'(sw(exp_dig[31:0])));

    // R4 window write while not ready
    n0 = ncap;
    bus_wr(A_DIN, 32'h12345678);
    bus_rd(A_CTRL, rd);
    chk(!rd[1] && ncap == n0, "R4 ignored window write", 64'(rd), 64'(4));

    // R10 R9 single full SHA-1 block with irq and dma enabled
    bus_wr(A_CFG, 32'hC);
    bus_wr(A_CTRL, (32'd64 << 5) | 32'h1D);
    chk(dma_req, "R10 dma request while input ready", 64'(dma_req), 1);
    bus_rd(A_CTRL, rd); chk(rd[1], "R3 nonzero length sets input ready", 64'(rd), 2);
    send_segment(1, 1, 1, 64);
    chk(!irq_n && !dma_req, "R9 R10 interrupt at completion", 64'({irq_n, dma_req}), 0);
    check_context(1, "sha");
    bus_wr(A_CTRL, 32'h1);
    chk(irq_n, "R9 output-ready clears on write of 1", 64'(irq_n), 1);

    // R7 restored MD5 context over two blocks
    for (int i = 0; i < 5; i++) begin
      logic [31:0] w = $urandom;
      bus_wr(7'(i*4), w);
      exp_dig[i*32 +: 32] = w;
    end
    bus_wr(A_CNT, 32'd1000); exp_cnt = 32'd1000;
    send_segment(0, 0, 0, 128);
    check_context(0, "md5");

    // R5 ten-byte closing tail
    send_segment(0, 0, 1, 10);

    // R3 abandon a segment with a zero length
    bus_wr(A_CTRL, (32'd64 << 5) | 32'h1);
    bus_wr(A_DIN, 32'haaaa5555); bus_wr(A_DIN + 7'd4, 32'h5555aaaa);
    bus_wr(A_CTRL, 32'h0);
    bus_rd(A_CTRL, rd);
    chk(!rd[1] && !dma_req, "R3 zero length idles", 64'(rd), 0);
    send_segment(0, 0, 1, 8);

    // random segments
    for (int t = 0; t < 8; t++) begin
      bit a = 1'($urandom);
      send_segment(a, 1'($urandom), 1'($urandom), $urandom_range(1, 200));
      check_context(a, "rand");
    end

    // R12 soft reset
    bus_wr(A_CFG, 32'h2);
    bus_rd(A_STAT, rd); chk(rd == 0, "R12 reset-done low next cycle", 64'(rd), 0);
    bus_rd(A_STAT, rd); chk(rd == 1, "R12 reset-done returns", 64'(rd), 1);
    bus_rd(A_CFG, rd);  chk(rd == 0, "R12 config cleared, bit self-clears", 64'(rd), 0);
    exp_dig = '0; exp_cnt = '0;
    check_context(0, "srst");
    bus_rd(A_CTRL, rd); chk(rd == 0, "R12 control cleared", 64'(rd), 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule